// File: doc/BRIEF.md
# Multi-mode reload/capture timer

This block is a 16-bit down-counter coupled to a 16-bit reload register that also serves as a capture register. Software reaches both through a small byte-wide register port. Each 16-bit value is split into a low and a high byte. Writes are staged and take effect together. A read of the low byte freezes the matching high byte, so the two halves of a read always belong together.

Three operating modes share the counter. In pulse-width mode the counter steps down on each tick strobe. When it steps down from zero it reloads, and it can flip the output pin at that moment. In event mode the counter steps down on edges of an asynchronous input pin, and software picks whether rising or falling edges count. In capture mode the counter runs freely on the tick strobe. A chosen edge of the pin copies the running count into the capture register. Any of these events can set a pending interrupt flag.

One control bit takes a different meaning in each mode. In pulse-width mode it enables the output toggle. In the other two modes it picks the edge polarity.

Top module: `mode_timer`

## Requirements
- R1: After reset the counter, the reload register and the control byte read 0, and `tmr_out_o` and `irq_o` are 0.
- R2: Register addresses are 0 control, 1 counter low, 2 counter high, 3 reload low and 4 reload high. A low-byte write only stages the byte. A write to the matching high byte loads {written byte, staged byte} in one step.
- R3: A low-byte read returns the live low byte and freezes the high byte of the same register. A later high-byte read returns that frozen byte, even if the count has moved since.
- R4: The control byte uses bits [1:0] for the mode (0 stopped, 1 pulse-width, 2 event, 3 capture), bit 4 for interrupt enable and bit 5 for the mode-dependent option. In pulse-width mode the counter decrements only in cycles where `tick_i` is 1.
- R5: In pulse-width and event mode a step taken at 0 loads the reload value N. The underflow period is therefore N+1 steps, from 1 (N=0) up to 65536 (N=0xFFFF).
- R6: In pulse-width mode with bit 5 set, each underflow inverts `tmr_out_o`. With bit 5 clear, the output holds its value.
- R7: In event mode the counter takes one step per synchronised edge of `evt_pin_i`: a rising edge when bit 5 is 0, a falling edge when it is 1. The opposite edge and `tick_i` have no effect.
- R8: In capture mode the counter decrements on `tick_i` and wraps from 0 to 0xFFFF without reloading. The selected edge of `evt_pin_i` (rising when bit 5 is 0, falling when it is 1) copies the count into the reload/capture register.
- R9: An underflow (pulse-width or event mode) or a capture sets the pending flag (control bit 7, shown on `irq_o`), but only while bit 4 is set. Writing a control byte with bit 7 set clears the flag.
- R10: In the stopped mode the counter never changes except by a register write.
- R11: A software write to the counter or to the reload register takes priority over a count step or a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count strobe for pulse-width and capture mode |
| evt_pin_i | input | 1 | Asynchronous external pin (events and captures) |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (a low-byte read freezes the high byte) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| tmr_out_o | output | 1 | Toggle output |
| irq_o | output | 1 | Pending interrupt flag |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 16-bit count and a two-stage pin synchroniser. At this width the full division range is short enough to sweep, including the largest reload of 0xFFFF (65536 ticks) and the smallest of 0 (one tick). The bench holds the tick strobe high for whole periods, so it can count exact periods at both ends of the range. Pin edges are held for several cycles, so each one passes the synchroniser before the count is read back through the byte port.

// File: rtl/mode_timer_pkg.sv
package mode_timer_pkg;

    typedef enum logic [1:0] {
        MD_STOP    = 2'd0,
        MD_PWM     = 2'd1,
        MD_EVENT   = 2'd2,
        MD_CAPTURE = 2'd3
    } tmr_mode_e;

    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_CNT_LO = 3'd1;
    localparam logic [2:0] RA_CNT_HI = 3'd2;
    localparam logic [2:0] RA_RLD_LO = 3'd3;
    localparam logic [2:0] RA_RLD_HI = 3'd4;

    localparam int CB_MODE = 0;
    localparam int CB_IEN  = 4;
    localparam int CB_ALT  = 5;
    localparam int CB_PEND = 7;

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin_i};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sh[STAGES-1] & ~st_q.prev;
    assign fall_o = ~st_q.sh[STAGES-1] & st_q.prev;

    // R7
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import mode_timer_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  rld_i,
    input  logic [BYTE_W-1:0] ctrl_i,
    output logic              ctrl_wr_o,
    output logic              cnt_wr_o,
    output logic              rld_wr_o,
    output logic [CNT_W-1:0]  wval_o,
    output logic [BYTE_W-1:0] rdata_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] stage;
        logic [BYTE_W-1:0] snap;
    } rif_st_t;

    rif_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i && (addr_i == RA_CNT_LO || addr_i == RA_RLD_LO))
            st_d.stage = wdata_i;
        if (rd_i && addr_i == RA_CNT_LO)
            st_d.snap = cnt_i[CNT_W-1:BYTE_W];
        else if (rd_i && addr_i == RA_RLD_LO)
            st_d.snap = rld_i[CNT_W-1:BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_wr_o = wr_i && (addr_i == RA_CTRL);
    assign cnt_wr_o  = wr_i && (addr_i == RA_CNT_HI);
    assign rld_wr_o  = wr_i && (addr_i == RA_RLD_HI);
    assign wval_o    = {wdata_i, st_q.stage};

    always_comb begin
        case (addr_i)
            RA_CTRL:   rdata_o = ctrl_i;
            RA_CNT_LO: rdata_o = cnt_i[BYTE_W-1:0];
            RA_RLD_LO: rdata_o = rld_i[BYTE_W-1:0];
            RA_CNT_HI,
            RA_RLD_HI: rdata_o = st_q.snap;
            default:   rdata_o = '0;
        endcase
    end

    // R3
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == RA_CNT_LO) |=> st_q.snap == $past(cnt_i[CNT_W-1:BYTE_W]));

    // R2
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && (addr_i == RA_CNT_LO || addr_i == RA_RLD_LO)) |=> $stable(st_q.stage));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import mode_timer_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              ctrl_wr_i,
    input  logic [BYTE_W-1:0] ctrl_wdata_i,
    input  logic              cnt_wr_i,
    input  logic              rld_wr_i,
    input  logic [CNT_W-1:0]  wval_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  rld_o,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic              out_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        tmr_mode_e        mode;
        logic             alt;
        logic             ien;
        logic             pend;
        logic             out;
    } core_st_t;

    core_st_t st_d, st_q;

    logic sel_edge, step, at_zero, underflow, capture;

    always_comb begin
        sel_edge  = st_q.alt ? fall_i : rise_i;
        case (st_q.mode)
            MD_PWM,
            MD_CAPTURE: step = tick_i;
            MD_EVENT:   step = sel_edge;
            default:    step = 1'b0;
        endcase
        at_zero   = (st_q.cnt == '0);
        underflow = step && at_zero && (st_q.mode == MD_PWM || st_q.mode == MD_EVENT);
        capture   = (st_q.mode == MD_CAPTURE) && sel_edge;

        st_d = st_q;
        if (step) begin
            if (!at_zero)                    st_d.cnt = st_q.cnt - 1'b1;
            else if (st_q.mode == MD_CAPTURE) st_d.cnt = '1;
            else                             st_d.cnt = st_q.rld;
        end
        if (underflow && st_q.mode == MD_PWM && st_q.alt)
            st_d.out = ~st_q.out;
        if (capture)
            st_d.rld = st_q.cnt;

        if (ctrl_wr_i) begin
            st_d.mode = tmr_mode_e'(ctrl_wdata_i[CB_MODE+1:CB_MODE]);
            st_d.ien  = ctrl_wdata_i[CB_IEN];
            st_d.alt  = ctrl_wdata_i[CB_ALT];
            if (ctrl_wdata_i[CB_PEND]) st_d.pend = 1'b0;
        end
        if ((underflow || capture) && st_q.ien)
            st_d.pend = 1'b1;

        if (cnt_wr_i) st_d.cnt = wval_i;
        if (rld_wr_i) st_d.rld = wval_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctrl_o                       = '0;
        ctrl_o[CB_MODE+1:CB_MODE]    = st_q.mode;
        ctrl_o[CB_IEN]               = st_q.ien;
        ctrl_o[CB_ALT]               = st_q.alt;
        ctrl_o[CB_PEND]              = st_q.pend;
    end

    assign cnt_o = st_q.cnt;
    assign rld_o = st_q.rld;
    assign out_o = st_q.out;
    assign irq_o = st_q.pend;

    // R4
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_PWM && !tick_i && !cnt_wr_i) |=> $stable(st_q.cnt));

    // R5
    reload_on_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_PWM && tick_i && st_q.cnt == '0 && !cnt_wr_i)
        |=> st_q.cnt == $past(st_q.rld));

    // R6
    out_toggle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.out) |-> $past(st_q.mode == MD_PWM && st_q.alt && tick_i && st_q.cnt == '0));

    // R8
    capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_CAPTURE && (st_q.alt ? fall_i : rise_i) && !rld_wr_i)
        |=> st_q.rld == $past(st_q.cnt));

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(st_q.ien));

    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_STOP && !cnt_wr_i) |=> $stable(st_q.cnt));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> st_q.cnt == $past(wval_i));
endmodule

// File: rtl/mode_timer.sv
module mode_timer
    import mode_timer_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              evt_pin_i,
    input  logic [2:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [BYTE_W-1:0] reg_wdata_i,
    output logic [BYTE_W-1:0] reg_rdata_o,
    output logic              tmr_out_o,
    output logic              irq_o
);
    logic              pin_rise, pin_fall;
    logic              ctrl_wr, cnt_wr, rld_wr;
    logic [CNT_W-1:0]  wval, cnt, rld;
    logic [BYTE_W-1:0] ctrl;

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (evt_pin_i),
        .rise_o(pin_rise),
        .fall_o(pin_fall)
    );

    tmr_regif #(.BYTE_W(BYTE_W)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (reg_addr_i),
        .wr_i     (reg_wr_i),
        .rd_i     (reg_rd_i),
        .wdata_i  (reg_wdata_i),
        .cnt_i    (cnt),
        .rld_i    (rld),
        .ctrl_i   (ctrl),
        .ctrl_wr_o(ctrl_wr),
        .cnt_wr_o (cnt_wr),
        .rld_wr_o (rld_wr),
        .wval_o   (wval),
        .rdata_o  (reg_rdata_o)
    );

    tmr_core #(.BYTE_W(BYTE_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .rise_i      (pin_rise),
        .fall_i      (pin_fall),
        .ctrl_wr_i   (ctrl_wr),
        .ctrl_wdata_i(reg_wdata_i),
        .cnt_wr_i    (cnt_wr),
        .rld_wr_i    (rld_wr),
        .wval_i      (wval),
        .cnt_o       (cnt),
        .rld_o       (rld),
        .ctrl_o      (ctrl),
        .out_o       (tmr_out_o),
        .irq_o       (irq_o)
    );
endmodule

// File: tb/tb_mode_timer.sv
module tb_mode_timer;
    localparam int CLK_PERIOD = 10;

    // {expected period (17 bits), reload value (16 bits)}
    localparam logic [32:0] PWM_VEC [6] = '{
        {17'd2,     16'd1},
        {17'd3,     16'd2},
        {17'd6,     16'd5},
        {17'd256,   16'd255},
        {17'd1,     16'd0},
        {17'd65536, 16'hFFFF}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       pin = 1'b0;
    logic [2:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tout, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mode_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .evt_pin_i(pin),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .tmr_out_o(tout), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr8(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] lo_a, input logic [15:0] v);
        wr8(lo_a, v[7:0]);
        wr8(lo_a + 3'd1, v[15:8]);
    endtask

    task automatic rd16(input logic [2:0] lo_a, output logic [15:0] v);
        addr = lo_a; rd = 1'b1;
        #1 v[7:0] = rdata;
        @(negedge clk);
        addr = lo_a + 3'd1;
        #1 v[15:8] = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic rd8(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
        @(negedge clk);
    endtask

    task automatic one_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        pin = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic measure(output int n);
        logic o0;
        int   g;
        tick = 1'b1;
        o0 = tout; g = 0;
        while (tout == o0 && g < 70000) begin @(negedge clk); g++; end
        o0 = tout; n = 0;
        do begin @(negedge clk); n++; end while (tout == o0 && n < 70000);
        tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        int          n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(tout == 1'b0, "R1", "out", tout, 0);
        chk(irq == 1'b0, "R1", "irq", irq, 0);
        rd8(3'd0, b);  chk(b == 8'h00, "R1", "ctrl", b, 0);
        rd16(3'd1, v); chk(v == 16'h0000, "R1", "counter", v, 0);
        rd16(3'd3, v); chk(v == 16'h0000, "R1", "reload", v, 0);

        // R2 staged write
        wr16(3'd1, 16'hABCD);
        wr8(3'd1, 8'h34);
        rd16(3'd1, v); chk(v == 16'hABCD, "R2", "low write alone", v, 16'hABCD);
        wr8(3'd2, 8'h12);
        rd16(3'd1, v); chk(v == 16'h1234, "R2", "commit on high", v, 16'h1234);

        // R3 coherent read: snapshot survives a count step
        wr16(3'd1, 16'h0100);
        wr8(3'd0, 8'h01);
        addr = 3'd1; rd = 1'b1;
        #1 b = rdata;
        @(negedge clk);
        rd = 1'b0;
        chk(b == 8'h00, "R3", "live low byte", b, 0);
        one_tick();
        rd8(3'd2, b); chk(b == 8'h01, "R3", "frozen high byte", b, 8'h01);
        rd16(3'd1, v); chk(v == 16'h00FF, "R4", "one tick decrement", v, 16'h00FF);

        // R4 no tick, no step
        repeat (5) @(negedge clk);
        rd16(3'd1, v); chk(v == 16'h00FF, "R4", "hold without tick", v, 16'h00FF);

        // R5 R6 period table
        for (int i = 0; i < 6; i++) begin
            wr8(3'd0, 8'h00);
            wr16(3'd3, PWM_VEC[i][15:0]);
            wr16(3'd1, 16'h0000);
            wr8(3'd0, 8'h21);
            measure(n);
            chk(n == int'(PWM_VEC[i][32:16]), "R5", "underflow period", n, PWM_VEC[i][32:16]);
        end

        // R6 no toggle with option clear
        wr16(3'd3, 16'd2);
        wr16(3'd1, 16'd0);
        wr8(3'd0, 8'h01);
        b[0] = tout;
        tick = 1'b1;
        repeat (10) @(negedge clk);
        tick = 1'b0;
        chk(tout == b[0], "R6", "out held with bit5 clear", tout, b[0]);

        // R10 stopped mode
        wr16(3'd1, 16'h0042);
        wr8(3'd0, 8'h00);
        tick = 1'b1;
        repeat (6) @(negedge clk);
        tick = 1'b0;
        rd16(3'd1, v); chk(v == 16'h0042, "R10", "stopped counter", v, 16'h0042);

        // R9 interrupt flag
        wr8(3'd0, 8'h80);
        wr16(3'd1, 16'h0000);
        wr8(3'd0, 8'h11);
        one_tick();
        chk(irq == 1'b1, "R9", "irq on underflow", irq, 1);
        wr8(3'd0, 8'h80);
        chk(irq == 1'b0, "R9", "irq cleared", irq, 0);
        wr16(3'd1, 16'h0000);
        wr8(3'd0, 8'h01);
        one_tick();
        chk(irq == 1'b0, "R9", "no irq when disabled", irq, 0);

        // R7 event mode, rising edges, ticks ignored
        wr8(3'd0, 8'h00);
        wr16(3'd3, 16'd5);
        wr16(3'd1, 16'd3);
        wr8(3'd0, 8'h12);
        tick = 1'b1;
        set_pin(1); set_pin(0);
        set_pin(1); set_pin(0);
        rd16(3'd1, v); chk(v == 16'd1, "R7", "two rising edges", v, 1);
        set_pin(1); set_pin(0);
        set_pin(1); set_pin(0);
        rd16(3'd1, v); chk(v == 16'd5, "R7", "event underflow reload", v, 5);
        chk(irq == 1'b1, "R9", "irq on event underflow", irq, 1);
        wr8(3'd0, 8'hB2);
        set_pin(1);
        rd16(3'd1, v); chk(v == 16'd5, "R7", "rising ignored in falling mode", v, 5);
        set_pin(0);
        rd16(3'd1, v); chk(v == 16'd4, "R7", "falling edge counts", v, 4);
        tick = 1'b0;

        // R8 capture mode
        wr8(3'd0, 8'h80);
        wr16(3'd3, 16'h0055);
        wr16(3'd1, 16'h1000);
        wr8(3'd0, 8'h13);
        set_pin(1);
        rd16(3'd3, v); chk(v == 16'h1000, "R8", "captured count", v, 16'h1000);
        chk(irq == 1'b1, "R9", "irq on capture", irq, 1);
        set_pin(0);
        repeat (3) one_tick();
        rd16(3'd1, v); chk(v == 16'h0FFD, "R8", "capture mode ticks", v, 16'h0FFD);
        wr16(3'd1, 16'h0000);
        one_tick();
        rd16(3'd1, v); chk(v == 16'hFFFF, "R8", "wrap without reload", v, 16'hFFFF);
        wr8(3'd0, 8'h23);
        set_pin(1);
        rd16(3'd3, v); chk(v == 16'h1000, "R8", "rising ignored in falling capture", v, 16'h1000);
        set_pin(0);
        rd16(3'd3, v); chk(v == 16'hFFFF, "R8", "falling capture", v, 16'hFFFF);

        // R11 write beats a step in the same cycle
        wr8(3'd0, 8'h01);
        wr8(3'd1, 8'h77);
        tick = 1'b1;
        addr = 3'd2; wdata = 8'h66; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        rd16(3'd1, v); chk(v == 16'h6677, "R11", "write over tick", v, 16'h6677);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule